// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the settings a clock synthesizer needs for its feedback and post dividers: a 9-bit loop divide value M and a 1-bit post-divider select N. A system can set them in two ways. One is a set of static pins, often strapped on the board, that feed M under an active-low parallel strobe. The other is a three-wire serial link with a shift clock, a data line and a load strobe, which can also set N. Both paths are transparent while their strobe is in its active level and freeze the value on the strobe edge that ends that level.

All strobes and the shift clock are slow signals. They are sampled on a fast system clock, and their edges are found by comparing successive samples. The stored M and N drive the divider logic from registers. A registered flag marks an M value that lies outside the range the loop can lock with.

Top module: `pll_divcfg`

## Requirements
- R1: While `pload_n` is low, `m_val` takes the value on `pm_in` two `clk` cycles later, and `m_out_of_range` follows that value.
- R2: On the rising edge of `pload_n`, the value on `pm_in` is captured. After that, neither changes on `pm_in` nor shift pulses with `ser_load` low alter `m_val` or `n_sel`.
- R3: Any parallel update forces `n_sel` to 0, even when an earlier serial load set it to 1.
- R4: Shift pulses given while `pload_n` is low do not enter the shift register. A serial load that follows a parallel capture replaces the parallel value.
- R5: A serial frame is 14 bits, sent most significant first on rising `ser_clk` edges: four ignored bits, then N, then M bit 8 down to M bit 0. On the rising edge of `ser_load`, the last ten bits shifted in are copied to N and M. N = 0 selects divide by 2, and N = 1 selects divide by 4.
- R6: On the falling edge of `ser_load`, M and N are frozen. Later shift pulses with `ser_load` low leave them unchanged.
- R7: While `ser_load` is high, each rising `ser_clk` edge shifts one bit in, and M and N at once take the new ten newest bits.
- R8: `m_out_of_range` is 1 exactly when the stored M is below 125 or above 350. It is updated in the same cycle as M.
- R9: The synchronous reset `rst` sets M to 0 and N to 0, and sets `m_out_of_range` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the whole block |
| rst | input | 1 | Synchronous active-high reset |
| pload_n | input | 1 | Parallel strobe, active low |
| pm_in | input | 9 | Parallel M value |
| ser_clk | input | 1 | Serial shift clock; acts on its rising edges |
| ser_din | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load strobe |
| m_val | output | 9 | Stored loop divide value |
| n_sel | output | 1 | Post-divider select: 0 = divide by 2, 1 = divide by 4 |
| m_out_of_range | output | 1 | Stored M lies outside 125..350 |

## Verification
The parallel path is swept over all 512 values of M. This covers both range limits and their neighbours, and it separates a correct flag from one that is off by one at either limit. Serial frames carry M values at the limits and alternating bit patterns with both N values. This shows the bit order and the placement of N, and it catches a swapped or shifted slot. Transparent shifting with `ser_load` high is compared bit by bit against a shadow register kept in the bench. Runs that mix the two modes show that pulses during a parallel load are ignored, that a serial load replaces a parallel capture, and that a parallel update clears N.

// File: rtl/pll_divcfg_pkg.sv
package pll_divcfg_pkg;

  localparam logic N_SEL_DIV2 = 1'b0;
  localparam logic N_SEL_DIV4 = 1'b1;

  typedef struct packed {
    logic pl_low;
    logic pl_rise;
    logic sl_high;
    logic sl_rise;
    logic sc_rise;
  } strobe_ev_t;

  typedef enum logic [1:0] {
    UPD_HOLD     = 2'd0,
    UPD_PARALLEL = 2'd1,
    UPD_SERIAL   = 2'd2
  } upd_sel_t;

  // Parallel activity wins over any serial event in the same cycle.
  function automatic upd_sel_t pick_update(input strobe_ev_t ev);
    if (ev.pl_low || ev.pl_rise)
      return UPD_PARALLEL;
    else if (ev.sl_rise || (ev.sl_high && ev.sc_rise))
      return UPD_SERIAL;
    else
      return UPD_HOLD;
  endfunction

endpackage

// File: rtl/pll_divcfg_sampler.sv
module pll_divcfg_sampler
  import pll_divcfg_pkg::*;
#(
  parameter int M_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pload_n,
  input  logic [M_W-1:0]      pm_in,
  input  logic                ser_clk,
  input  logic                ser_din,
  input  logic                ser_load,
  output strobe_ev_t          ev,
  output logic [M_W-1:0]      pm_q,
  output logic                din_q
);

  logic pl_q, pl_d;
  logic sc_q, sc_d;
  logic sl_q, sl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pl_q  <= 1'b1;
      pl_d  <= 1'b1;
      sc_q  <= 1'b0;
      sc_d  <= 1'b0;
      sl_q  <= 1'b0;
      sl_d  <= 1'b0;
      pm_q  <= '0;
      din_q <= 1'b0;
    end else begin
      pl_q  <= pload_n;
      pl_d  <= pl_q;
      sc_q  <= ser_clk;
      sc_d  <= sc_q;
      sl_q  <= ser_load;
      sl_d  <= sl_q;
      pm_q  <= pm_in;
      din_q <= ser_din;
    end
  end

  always_comb begin
    ev.pl_low  = ~pl_q;
    ev.pl_rise = pl_q & ~pl_d;
    ev.sl_high = sl_q;
    ev.sl_rise = sl_q & ~sl_d;
    ev.sc_rise = sc_q & ~sc_d;
  end

endmodule

// File: rtl/pll_divcfg_shifter.sv
module pll_divcfg_shifter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);

  assign q_next = {q[W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (shift_en)
      q <= q_next;
  end

endmodule

// File: rtl/pll_divcfg_regs.sv
module pll_divcfg_regs
  import pll_divcfg_pkg::*;
#(
  parameter int M_W   = 9,
  parameter int M_MIN = 125,
  parameter int M_MAX = 350
) (
  input  logic            clk,
  input  logic            rst,
  input  upd_sel_t        sel,
  input  logic [M_W-1:0]  pm,
  input  logic [M_W:0]    ser_word,
  output logic [M_W-1:0]  m_val,
  output logic            n_sel,
  output logic            m_bad
);

  localparam int          M_TOP = (1 << M_W) - 1;
  localparam logic [M_W-1:0] MIN_V = M_W'(M_MIN);
  localparam logic [M_W-1:0] MAX_V = M_W'(M_MAX);

  logic [M_W-1:0] m_nxt;
  logic           n_nxt;
  logic           lo_bad, hi_bad;
  logic           bad_at_zero;

  always_comb begin
    m_nxt = m_val;
    n_nxt = n_sel;
    case (sel)
      UPD_PARALLEL: begin
        m_nxt = pm;
        n_nxt = N_SEL_DIV2;
      end
      UPD_SERIAL: begin
        m_nxt = ser_word[M_W-1:0];
        n_nxt = ser_word[M_W];
      end
      default: ;
    endcase
  end

  generate
    if (M_MIN > 0) begin : g_lo
      assign lo_bad = (m_nxt < MIN_V);
    end else begin : g_nolo
      assign lo_bad = 1'b0;
    end
    if (M_MAX < M_TOP) begin : g_hi
      assign hi_bad = (m_nxt > MAX_V);
    end else begin : g_nohi
      assign hi_bad = 1'b0;
    end
  endgenerate

  assign bad_at_zero = (M_MIN > 0);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_val <= '0;
      n_sel <= N_SEL_DIV2;
      m_bad <= bad_at_zero;
    end else begin
      m_val <= m_nxt;
      n_sel <= n_nxt;
      m_bad <= lo_bad | hi_bad;
    end
  end

endmodule

// File: rtl/pll_divcfg.sv
module pll_divcfg
  import pll_divcfg_pkg::*;
#(
  parameter int M_W   = 9,
  parameter int M_MIN = 125,
  parameter int M_MAX = 350
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pload_n,
  input  logic [M_W-1:0] pm_in,
  input  logic           ser_clk,
  input  logic           ser_din,
  input  logic           ser_load,
  output logic [M_W-1:0] m_val,
  output logic           n_sel,
  output logic           m_out_of_range
);

  localparam int SH_W = M_W + 1;

  strobe_ev_t      ev;
  logic [M_W-1:0]  pm_q;
  logic            din_q;
  logic            shift_en;
  logic [SH_W-1:0] sh_q, sh_next, ser_word;
  upd_sel_t        sel;

  pll_divcfg_sampler #(.M_W(M_W)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .pload_n  (pload_n),
    .pm_in    (pm_in),
    .ser_clk  (ser_clk),
    .ser_din  (ser_din),
    .ser_load (ser_load),
    .ev       (ev),
    .pm_q     (pm_q),
    .din_q    (din_q)
  );

  // Shifting is blocked while the parallel strobe is active.
  assign shift_en = ev.sc_rise & ~ev.pl_low;

  pll_divcfg_shifter #(.W(SH_W)) u_shifter (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .din      (din_q),
    .q        (sh_q),
    .q_next   (sh_next)
  );

  assign ser_word = shift_en ? sh_next : sh_q;
  assign sel      = pick_update(ev);

  pll_divcfg_regs #(.M_W(M_W), .M_MIN(M_MIN), .M_MAX(M_MAX)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .pm       (pm_q),
    .ser_word (ser_word),
    .m_val    (m_val),
    .n_sel    (n_sel),
    .m_bad    (m_out_of_range)
  );

endmodule

// File: rtl/pll_divcfg_chk.sv
module pll_divcfg_chk #(
  parameter int M_W   = 9,
  parameter int M_MIN = 125,
  parameter int M_MAX = 350
) (
  input logic           clk,
  input logic           rst,
  input logic           pload_n,
  input logic [M_W-1:0] pm_in,
  input logic           ser_load,
  input logic [M_W-1:0] m_val,
  input logic           n_sel,
  input logic           m_out_of_range
);

  logic [2:0] age;

  always_ff @(posedge clk) begin
    if (rst)
      age <= '0;
    else if (age != 3'd7)
      age <= age + 3'd1;
  end

  // R1
  par_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd3 && !$past(pload_n, 2)) |-> (m_val == $past(pm_in, 2)));

  // R3
  par_n_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd3 && !$past(pload_n, 2)) |-> !n_sel);

  // R2
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && $past(pload_n, 2) && $past(pload_n, 3) &&
     !$past(ser_load, 2) && !$past(ser_load, 3))
    |-> ($stable(m_val) && $stable(n_sel)));

  // R8
  range_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1) |->
    (m_out_of_range == ((int'(m_val) < M_MIN) || (int'(m_val) > M_MAX))));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (m_val == '0 && !n_sel));

endmodule

bind pll_divcfg pll_divcfg_chk #(.M_W(M_W), .M_MIN(M_MIN), .M_MAX(M_MAX)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .pload_n        (pload_n),
  .pm_in          (pm_in),
  .ser_load       (ser_load),
  .m_val          (m_val),
  .n_sel          (n_sel),
  .m_out_of_range (m_out_of_range)
);

// File: tb/pll_divcfg_tb.sv
module pll_divcfg_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       pload_n;
  logic [8:0] pm_in;
  logic       ser_clk;
  logic       ser_din;
  logic       ser_load;
  logic [8:0] m_val;
  logic       n_sel;
  logic       m_out_of_range;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [9:0] sh = '0;

  always #4 clk = ~clk;

  pll_divcfg u_dut (
    .clk            (clk),
    .rst            (rst),
    .pload_n        (pload_n),
    .pm_in          (pm_in),
    .ser_clk        (ser_clk),
    .ser_din        (ser_din),
    .ser_load       (ser_load),
    .m_val          (m_val),
    .n_sel          (n_sel),
    .m_out_of_range (m_out_of_range)
  );

  function automatic logic bad(input logic [8:0] v);
    return (v < 9'd125) || (v > 9'd350);
  endfunction

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [8:0] em, input logic en);
    logic eb;
    eb = bad(em);
    checks++;
    if (m_val !== em || n_sel !== en || m_out_of_range !== eb) begin
      fails++;
      $display("FAIL %s: m=%0d n=%0b flag=%0b expected m=%0d n=%0b flag=%0b",
               req, m_val, n_sel, m_out_of_range, em, en, eb);
    end
  endtask

  task automatic pulse(input logic b);
    ser_din = b;
    ser_clk = 1'b1;
    settle();
    ser_clk = 1'b0;
    settle();
    if (pload_n) sh = {sh[8:0], b};
  endtask

  task automatic send_frame(input logic n, input logic [8:0] m);
    logic [13:0] bits;
    bits = {4'b1011, n, m};
    for (int i = 13; i >= 0; i--) pulse(bits[i]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [8:0] vals [9];
    rst = 1'b1; pload_n = 1'b1; pm_in = '0;
    ser_clk = 1'b0; ser_din = 1'b0; ser_load = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset", 9'd0, 1'b0);
    rst = 1'b0;
    settle();
    chk("R9 after release", 9'd0, 1'b0);

    // R1 R8: full parallel sweep
    pload_n = 1'b0;
    for (int v = 0; v < 512; v++) begin
      pm_in = 9'(v);
      settle();
      chk("R1 R8 sweep", 9'(v), 1'b0);
    end

    // R2: capture and hold
    pm_in = 9'd200;
    settle();
    pload_n = 1'b1;
    settle();
    pm_in = 9'd77;
    settle();
    chk("R2 capture", 9'd200, 1'b0);
    pulse(1'b1); pulse(1'b0);
    chk("R2 shift ignored", 9'd200, 1'b0);

    // R5 R6: full frames, both N values, limit values
    vals = '{9'd0, 9'd1, 9'd124, 9'd125, 9'd256, 9'd350, 9'd351, 9'h155, 9'h0AA};
    for (int k = 0; k < 9; k++) begin
      logic nn;
      nn = k[0];
      send_frame(nn, vals[k]);
      ser_load = 1'b1;
      settle();
      chk("R5 frame", vals[k], nn);
      ser_load = 1'b0;
      settle();
      pulse(~nn); pulse(nn); pulse(1'b1);
      chk("R6 held", vals[k], nn);
    end

    // R7: transparent shifting
    send_frame(1'b1, 9'd300);
    ser_load = 1'b1;
    settle();
    chk("R7 enter", 9'd300, 1'b1);
    for (int k = 0; k < 12; k++) begin
      pulse(k % 3 == 0);
      chk("R7 follow", sh[8:0], sh[9]);
    end
    ser_load = 1'b0;
    settle();
    begin
      logic [9:0] keep;
      keep = sh;
      pulse(1'b0); pulse(1'b1);
      chk("R6 after transparent", keep[8:0], keep[9]);
    end

    // R3 R4: mode interplay
    send_frame(1'b1, 9'd222);
    ser_load = 1'b1; settle(); ser_load = 1'b0; settle();
    chk("R5 preload", 9'd222, 1'b1);
    pload_n = 1'b0;
    pm_in = 9'd300;
    settle();
    chk("R3 n cleared", 9'd300, 1'b0);
    for (int k = 0; k < 10; k++) pulse(1'b0);
    pload_n = 1'b1;
    settle();
    chk("R4 parallel capture", 9'd300, 1'b0);
    ser_load = 1'b1;
    settle();
    chk("R4 serial override", 9'd222, 1'b1);
    ser_load = 1'b0;
    settle();

    // R9: reset mid-run
    rst = 1'b1;
    settle();
    chk("R9 mid-run reset", 9'd0, 1'b0);
    rst = 1'b0;
    settle();
    chk("R9 hold after reset", 9'd0, 1'b0);

    finish_run();
  end

endmodule